// File: doc/BRIEF.md
# Four-Channel Simultaneous-Sampling Converter Sequencer

This block is the digital control core of a four-channel converter whose channels are all held at the same instant. A rising edge on the start input captures a channel-enable mask. In hardware mode the mask comes from four select pins. In software mode it comes from a small register written over the parallel bus. The block then converts the enabled channels one at a time, each taking a fixed number of conversion clocks, and drives a busy flag over the whole run and an active-low end-of-conversion pulse after each channel.

The analog conversion is modelled by a code input. While a channel is being converted, the block shows that channel's index on `conv_ch`. It samples `sample_code` on the last conversion clock of the slot. Results are kept in conversion order and read back over an active-low chip-select/read bus. A pointer walks the results, and `first_data` flags the first one. The conversion clock comes from an internal divider of the system clock. In software mode it can come from an external tick input instead.

Top module: `adc_seq_core`

## Requirements
- R1: `busy` rises on the clock after a rising edge on `conv_start` (with `stby_n` high and the block idle). With the internal clock it stays high for exactly 16·CLK_DIV·n cycles, where n is the number of enabled channels. With an empty mask it stays high for one cycle. After reset, `busy` is 0, `eoc_n` is 1, `dout_oe` is 0 and `first_data` is 1.
- R2: When `sw_mode` is 0, the mask is `hw_sel`, where bit i enables channel i+1 (1 = include). The internal clock is used even if `ext_clk_sel` is 1.
- R3: When `sw_mode` is 1, the mask is a 4-bit select register that resets to 4'b1111. It loads `db_in[3:0]` on a rising edge of `wr_n` while `cs_n` is 0 and `rd_n` is 1. Bit 0 is channel 1. A write while `rd_n` is 0 is ignored.
- R4: The mask is captured at the start edge. Changes to `hw_sel` or the select register during a run do not change that run.
- R5: Enabled channels are converted in ascending index order. Result k holds the `sample_code` value seen while `conv_ch` showed the k-th enabled channel.
- R6: `eoc_n` goes low once at the end of each channel's conversion and stays low for one conversion clock (CLK_DIV cycles with the internal clock).
- R7: `dout_oe` is 1 only while `cs_n` and `rd_n` are both 0. Otherwise `dout` is 0.
- R8: With `fmt_twos` 0, `dout` is the straight-binary code. With `fmt_twos` 1, `dout` is that code with bit 13 inverted (two's complement).
- R9: The read pointer returns to the first result at each start. It advances on a rising edge of `rd_n` while `cs_n` is 0, and wraps after the last result. `first_data` is 1 exactly while the pointer is at the first result.
- R10: While `stby_n` is 0, `conv_start` edges are ignored and the stored results are kept.
- R11: A `conv_start` edge while `busy` is high is ignored.
- R12: With `sw_mode` 1 and `ext_clk_sel` 1, each `ext_tick` pulse is one conversion clock, so a channel completes after 16 pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_start | input | 1 | Start input; a rising edge begins a run |
| stby_n | input | 1 | Low puts the block in standby |
| sw_mode | input | 1 | 1 = register mask, 0 = pin mask |
| ext_clk_sel | input | 1 | In software mode, 1 uses `ext_tick` as the conversion clock |
| ext_tick | input | 1 | External conversion clock pulse, one system cycle wide |
| hw_sel | input | 4 | Pin channel enables |
| cs_n | input | 1 | Bus chip select, active low |
| rd_n | input | 1 | Bus read strobe, active low |
| wr_n | input | 1 | Bus write strobe, active low |
| db_in | input | 4 | Bus write data for the select register |
| fmt_twos | input | 1 | Output coding: 1 = two's complement |
| sample_code | input | 14 | Modelled conversion result for `conv_ch` |
| conv_ch | output | 2 | Index of the channel being converted |
| busy | output | 1 | High for the whole run |
| eoc_n | output | 1 | Active-low pulse after each channel |
| first_data | output | 1 | Read pointer at the first result |
| dout | output | 14 | Read data |
| dout_oe | output | 1 | Read data valid (bus enable) |

## Verification
The bench builds the block with CLK_DIV set to 3, so that the divider is not a power of two. The expected busy and end-of-conversion lengths are then products of 16 and an odd factor, and off-by-one errors in the divider or the slot counter show up as wrong cycle counts. With four channels and 16-clock slots, a full run lasts at most 192 cycles. This lets many random masks, modes and coding choices fit in the run, next to directed cases for the empty mask, standby, restarts during a run and external ticks.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int MAX_CH = 16;

  // index of lowest set bit, 0 if none
  function automatic logic [3:0] lowest_idx(input logic [MAX_CH-1:0] m);
    logic [3:0] idx;
    idx = '0;
    for (int i = MAX_CH - 1; i >= 0; i--) begin
      if (m[i]) idx = 4'(i);
    end
    return idx;
  endfunction

  function automatic logic [4:0] count_ones(input logic [MAX_CH-1:0] m);
    logic [4:0] n;
    n = '0;
    for (int i = 0; i < MAX_CH; i++) n = n + 5'(m[i]);
    return n;
  endfunction
endpackage

// File: rtl/adc_tick_gen.sv
module adc_tick_gen #(
  parameter int CLK_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  input  logic use_ext,
  input  logic ext_tick,
  output logic tick
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  logic [DIV_W-1:0] cnt;
  logic             int_tick;

  assign int_tick = run && (cnt == DIV_LAST);
  assign tick     = use_ext ? (run && ext_tick) : int_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (clear || !run)     cnt <= '0;
    else if (cnt == DIV_LAST)   cnt <= '0;
    else                        cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/adc_chan_seq.sv
module adc_chan_seq #(
  parameter int NUM_CH    = 4,
  parameter int SLOT_CLKS = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_evt,
  input  logic [NUM_CH-1:0]          sel_mask,
  input  logic                       tick,
  output logic                       busy,
  output logic                       eoc_n,
  output logic [$clog2(NUM_CH)-1:0]  cur_ch,
  output logic                       slot_done,
  output logic [$clog2(NUM_CH)-1:0]  store_idx,
  output logic [NUM_CH-1:0]          mask_q
);
  import adc_seq_pkg::*;
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int SLOT_W = $clog2(SLOT_CLKS);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOT_CLKS - 1);

  logic [NUM_CH-1:0] remain;
  logic [NUM_CH-1:0] cur_bit;
  logic [SLOT_W-1:0] slot;
  logic [CH_W-1:0]   wr_idx;

  assign cur_ch    = CH_W'(lowest_idx(MAX_CH'(remain)));
  assign cur_bit   = NUM_CH'(1) << cur_ch;
  assign slot_done = busy && (remain != '0) && tick && (slot == SLOT_LAST);
  assign store_idx = wr_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      eoc_n  <= 1'b1;
      remain <= '0;
      mask_q <= '0;
      slot   <= '0;
      wr_idx <= '0;
    end else if (start_evt) begin
      busy   <= 1'b1;
      eoc_n  <= 1'b1;
      remain <= sel_mask;
      mask_q <= sel_mask;
      slot   <= '0;
      wr_idx <= '0;
    end else begin
      if (!eoc_n && tick) eoc_n <= 1'b1;
      if (busy && remain == '0) begin
        busy <= 1'b0;
      end else if (busy && tick) begin
        if (slot_done) begin
          slot   <= '0;
          remain <= remain & ~cur_bit;
          wr_idx <= wr_idx + CH_W'(1);
          eoc_n  <= 1'b0;
          if ((remain & ~cur_bit) == '0) busy <= 1'b0;
        end else begin
          slot <= slot + SLOT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int NUM_CH = 4,
  parameter int RES_W  = 14
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_evt,
  input  logic                       store_en,
  input  logic [$clog2(NUM_CH)-1:0]  store_idx,
  input  logic [RES_W-1:0]           store_data,
  input  logic [NUM_CH-1:0]          mask_q,
  input  logic                       cs_n,
  input  logic                       rd_n,
  input  logic                       fmt_twos,
  output logic [RES_W-1:0]           dout,
  output logic                       dout_oe,
  output logic                       first_data
);
  import adc_seq_pkg::*;
  localparam int CH_W  = $clog2(NUM_CH);
  localparam int CNT_W = $clog2(NUM_CH + 1);

  logic [RES_W-1:0] res [NUM_CH];
  logic [CH_W-1:0]  ptr;
  logic [CNT_W-1:0] n_en;
  logic [CNT_W-1:0] ptr_next;
  logic             rd_q;
  logic             rd_done;

  function automatic logic [RES_W-1:0] apply_fmt(input logic [RES_W-1:0] raw,
                                                 input logic twos);
    return twos ? {~raw[RES_W-1], raw[RES_W-2:0]} : raw;
  endfunction

  assign n_en       = CNT_W'(count_ones(MAX_CH'(mask_q)));
  assign ptr_next   = CNT_W'(ptr) + CNT_W'(1);
  assign rd_done    = !cs_n && rd_n && !rd_q;
  assign dout_oe    = !cs_n && !rd_n;
  assign dout       = dout_oe ? apply_fmt(res[ptr], fmt_twos) : '0;
  assign first_data = (ptr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b1;
      ptr  <= '0;
      for (int i = 0; i < NUM_CH; i++) res[i] <= '0;
    end else begin
      rd_q <= rd_n;
      if (store_en) res[store_idx] <= store_data;
      if (start_evt)    ptr <= '0;
      else if (rd_done) ptr <= (ptr_next >= n_en) ? '0 : CH_W'(ptr_next);
    end
  end
endmodule

// File: rtl/adc_seq_core.sv
module adc_seq_core #(
  parameter int NUM_CH    = 4,
  parameter int RES_W     = 14,
  parameter int SLOT_CLKS = 16,
  parameter int CLK_DIV   = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       conv_start,
  input  logic                       stby_n,
  input  logic                       sw_mode,
  input  logic                       ext_clk_sel,
  input  logic                       ext_tick,
  input  logic [NUM_CH-1:0]          hw_sel,
  input  logic                       cs_n,
  input  logic                       rd_n,
  input  logic                       wr_n,
  input  logic [NUM_CH-1:0]          db_in,
  input  logic                       fmt_twos,
  input  logic [RES_W-1:0]           sample_code,
  output logic [$clog2(NUM_CH)-1:0]  conv_ch,
  output logic                       busy,
  output logic                       eoc_n,
  output logic                       first_data,
  output logic [RES_W-1:0]           dout,
  output logic                       dout_oe
);
  localparam int CH_W = $clog2(NUM_CH);

  logic              conv_q, wr_q, use_ext_q;
  logic [NUM_CH-1:0] sel_reg;
  logic [NUM_CH-1:0] sel_mask;
  logic [NUM_CH-1:0] mask_q;
  logic              start_evt, wr_evt, tick, slot_done;
  logic [CH_W-1:0]   store_idx;

  assign start_evt = conv_start && !conv_q && stby_n && !busy;
  assign wr_evt    = wr_n && !wr_q && !cs_n && rd_n;
  assign sel_mask  = sw_mode ? sel_reg : hw_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_q    <= 1'b1;
      wr_q      <= 1'b1;
      use_ext_q <= 1'b0;
      sel_reg   <= '1;
    end else begin
      conv_q <= conv_start;
      wr_q   <= wr_n;
      if (wr_evt)    sel_reg   <= db_in;
      if (start_evt) use_ext_q <= sw_mode && ext_clk_sel;
    end
  end

  adc_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy || !eoc_n),
    .clear    (start_evt),
    .use_ext  (use_ext_q),
    .ext_tick (ext_tick),
    .tick     (tick)
  );

  adc_chan_seq #(.NUM_CH(NUM_CH), .SLOT_CLKS(SLOT_CLKS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_evt (start_evt),
    .sel_mask  (sel_mask),
    .tick      (tick),
    .busy      (busy),
    .eoc_n     (eoc_n),
    .cur_ch    (conv_ch),
    .slot_done (slot_done),
    .store_idx (store_idx),
    .mask_q    (mask_q)
  );

  adc_result_bank #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u_res (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_evt  (start_evt),
    .store_en   (slot_done),
    .store_idx  (store_idx),
    .store_data (sample_code),
    .mask_q     (mask_q),
    .cs_n       (cs_n),
    .rd_n       (rd_n),
    .fmt_twos   (fmt_twos),
    .dout       (dout),
    .dout_oe    (dout_oe),
    .first_data (first_data)
  );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int NUM_CH = 4,
  parameter int RES_W  = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              conv_start,
  input logic              stby_n,
  input logic              cs_n,
  input logic              rd_n,
  input logic              busy,
  input logic              eoc_n,
  input logic              first_data,
  input logic [RES_W-1:0]  dout,
  input logic              dout_oe,
  input logic              start_evt,
  input logic              slot_done,
  input logic [NUM_CH-1:0] mask_q
);
  assert_busy_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(conv_start && stby_n));

  assert_mask_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mask_q));

  assert_eoc_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eoc_n) |-> $past(slot_done));

  assert_bus_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || rd_n) |-> (!dout_oe && dout == '0));

  assert_first_after_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start_evt) |-> first_data);

  assert_stby_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!stby_n && !busy) |=> !busy);
endmodule

bind adc_seq_core adc_seq_chk #(.NUM_CH(NUM_CH), .RES_W(RES_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .conv_start (conv_start),
  .stby_n     (stby_n),
  .cs_n       (cs_n),
  .rd_n       (rd_n),
  .busy       (busy),
  .eoc_n      (eoc_n),
  .first_data (first_data),
  .dout       (dout),
  .dout_oe    (dout_oe),
  .start_evt  (start_evt),
  .slot_done  (slot_done),
  .mask_q     (mask_q)
);

// File: tb/adc_seq_core_tb.sv
`timescale 1ns/1ps
module adc_seq_core_tb_top;
  localparam int D = 3;
  localparam int SLOT = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_start = 1'b0, stby_n = 1'b1, sw_mode = 1'b0;
  logic        ext_clk_sel = 1'b0, ext_tick = 1'b0;
  logic [3:0]  hw_sel = 4'h0, db_in = 4'h0;
  logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, fmt_twos = 1'b0;
  logic [13:0] sample_code;
  logic [1:0]  conv_ch;
  logic        busy, eoc_n, first_data, dout_oe;
  logic [13:0] dout;
  logic [13:0] chan_code [4];

  int n_chk = 0, n_bad = 0;
  logic [3:0] run_mask;
  int         bptr;
  bit         done = 0;

  always #5 clk = ~clk;
  assign sample_code = chan_code[conv_ch];

  adc_seq_core #(.CLK_DIV(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .stby_n(stby_n),
    .sw_mode(sw_mode), .ext_clk_sel(ext_clk_sel), .ext_tick(ext_tick),
    .hw_sel(hw_sel), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .db_in(db_in),
    .fmt_twos(fmt_twos), .sample_code(sample_code), .conv_ch(conv_ch),
    .busy(busy), .eoc_n(eoc_n), .first_data(first_data), .dout(dout),
    .dout_oe(dout_oe));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ones(input logic [3:0] m);
    int c = 0;
    for (int i = 0; i < 4; i++) if (m[i]) c++;
    return c;
  endfunction

  function automatic int nth_ch(input logic [3:0] m, input int k);
    int seen = 0;
    for (int i = 0; i < 4; i++) if (m[i]) begin
      if (seen == k) return i;
      seen++;
    end
    return 0;
  endfunction

  function automatic int coded(input logic [13:0] raw, input bit twos);
    return twos ? int'(raw ^ 14'h2000) : int'(raw);
  endfunction

  task automatic bus_write(input logic [3:0] v, input bit rd_low);
    @(negedge clk); cs_n = 0; rd_n = rd_low ? 1'b0 : 1'b1; db_in = v; wr_n = 0;
    @(negedge clk); wr_n = 1;
    @(negedge clk); cs_n = 1; rd_n = 1;
  endtask

  // start a run with internal clock and measure busy / eoc
  task automatic run_conv(input logic [3:0] exp_mask, input bit perturb);
    int bc = 0, el = 0, falls = 0, cyc = 0;
    logic prev_eoc = 1'b1;
    for (int c = 0; c < 4; c++) chan_code[c] = 14'($urandom);
    run_mask = exp_mask;
    @(negedge clk); conv_start = 1;
    forever begin
      @(negedge clk);
      conv_start = 0;
      cyc++;
      if (busy) bc++;
      if (!eoc_n) el++;
      if (prev_eoc && !eoc_n) falls++;
      prev_eoc = eoc_n;
      if (perturb && cyc == 5)  begin hw_sel = ~hw_sel; cs_n = 0; db_in = ~db_in; wr_n = 0; end
      if (perturb && cyc == 6)  wr_n = 1;
      if (perturb && cyc == 7)  cs_n = 1;
      if (perturb && cyc == 8)  conv_start = 1;
      if (!busy && eoc_n) break;
      if (cyc > 1000) break;
    end
    bptr = 0;
    chk(bc == ((ones(exp_mask) == 0) ? 1 : SLOT * D * ones(exp_mask)),
        perturb ? "R1/R4/R11 busy length" : "R1 busy length", bc,
        (ones(exp_mask) == 0) ? 1 : SLOT * D * ones(exp_mask));
    chk(falls == ones(exp_mask), "R6 eoc pulse count", falls, ones(exp_mask));
    chk(el == D * ones(exp_mask), "R6 eoc low cycles", el, D * ones(exp_mask));
  endtask

  task automatic read_back(input int count);
    int n = ones(run_mask);
    for (int k = 0; k < count; k++) begin
      @(negedge clk); cs_n = 0;
      chk(!dout_oe && dout == 0, "R7 idle without rd", int'(dout), 0);
      rd_n = 0;
      @(negedge clk);
      chk(dout_oe, "R7 oe during read", int'(dout_oe), 1);
      chk(int'(dout) == coded(chan_code[nth_ch(run_mask, bptr)], fmt_twos),
          "R5/R8 read data", int'(dout), coded(chan_code[nth_ch(run_mask, bptr)], fmt_twos));
      chk(first_data == (bptr == 0), "R9 first flag", int'(first_data), int'(bptr == 0));
      rd_n = 1;
      @(negedge clk); cs_n = 1;
      bptr = (bptr + 1 >= n) ? 0 : bptr + 1;
    end
  endtask

  initial begin
    logic [3:0] m;
    process::self().srandom(32'd2024);
    for (int c = 0; c < 4; c++) chan_code[c] = '0;
    repeat (3) @(negedge clk);
    chk(!busy && eoc_n && !dout_oe && first_data, "R1 reset state",
        int'({busy, eoc_n, dout_oe, first_data}), 5);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2: hardware mask, ext select ignored
    sw_mode = 0; ext_clk_sel = 1; hw_sel = 4'b1010;
    run_conv(4'b1010, 0); read_back(3);
    ext_clk_sel = 0;

    // R3: register mask, write with rd low ignored
    sw_mode = 1;
    bus_write(4'b0101, 0);
    bus_write(4'b1111, 1);
    run_conv(4'b0101, 0); fmt_twos = 1; read_back(3);

    // empty mask
    hw_sel = 4'b0000; sw_mode = 0;
    run_conv(4'b0000, 0);

    // R4/R11: perturb mid-run
    hw_sel = 4'b1001;
    run_conv(4'b1001, 1); read_back(2);

    // R10: standby
    sw_mode = 0; hw_sel = 4'b1111; stby_n = 0;
    @(negedge clk); conv_start = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); conv_start = 0;
      chk(!busy, "R10 standby ignores start", int'(busy), 0);
    end
    stby_n = 1;
    read_back(1);

    // R12: external ticks, channels 2 and 4
    sw_mode = 1; ext_clk_sel = 1;
    bus_write(4'b1010, 0);
    for (int c = 0; c < 4; c++) chan_code[c] = 14'($urandom);
    run_mask = 4'b1010; bptr = 0;
    @(negedge clk); conv_start = 1;
    @(negedge clk); conv_start = 0;
    for (int t = 0; t < 2 * SLOT; t++) begin
      chk(busy, "R12 busy before last ext tick", int'(busy), 1);
      ext_tick = 1; @(negedge clk); ext_tick = 0;
      repeat (2) @(negedge clk);
    end
    chk(!busy && !eoc_n, "R12 done after 32 ticks", int'({busy, eoc_n}), 0);
    ext_tick = 1; @(negedge clk); ext_tick = 0; @(negedge clk);
    chk(eoc_n, "R12 eoc released by next tick", int'(eoc_n), 1);
    fmt_twos = 0; read_back(2);
    ext_clk_sel = 0;

    // random mix
    for (int it = 0; it < 20; it++) begin
      m = 4'($urandom);
      fmt_twos = 1'($urandom);
      sw_mode = 1'($urandom);
      if (sw_mode) bus_write(m, 0); else hw_sel = m;
      run_conv(m, (ones(m) > 0) && ($urandom % 2 == 1));
      if (ones(m) > 0) read_back(ones(m) + 1);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule